// File: doc/BRIEF.md
# Bit-Serial Carry-Save Multiplier

This block multiplies two unsigned N-bit operands and returns the 2N-bit product on a single wire, one bit per clock, least significant bit first. The multiplicand Y is shifted into a holding register, one bit for each load strobe. The multiplier X then arrives one bit per clock. Each clock, the current X bit is ANDed with every stored Y bit. The resulting partial products go into a row of N single-bit full adders. Each adder keeps its carry in place and passes only its sum bit one stage toward the output.

X bits are accepted for N cycles. For the next N cycles zeros are fed instead, so the saved carries drain out as the upper half of the product. At the start of an operation the holding register is copied into a working register. The next Y can therefore be shifted in while the current product is still being computed. A new operation may start in the last busy cycle, so products follow one another with no gap.

Top module: `msm_serial_mult`

## Requirements
- R1: While rst_n is low, busy, p_valid and p_bit are all 0.
- R2: Each clock with y_load high shifts y_bit into the holding register from the most significant end. After N strobes, the first strobed bit is Y bit 0. With y_load low the register holds its value, and y_bit is ignored.
- R3: While idle, a clock edge with x_valid high starts an operation and takes x_bit as X bit 0. X bits 1 to N-1 are taken at the next N-1 edges, each as x_bit AND x_valid, so a low x_valid supplies a 0 bit.
- R4: busy is high for exactly 2N cycles, starting with the cycle after the starting edge.
- R5: p_valid is high in the cycle after each busy cycle. In the k-th such cycle (counting from 0), p_bit carries product bit k, so the 2N bits form X*Y.
- R6: The Y used by an operation is the holding register's content at the starting edge. Strobes during any busy cycle, including the last N, leave the product in flight unchanged.
- R7: While busy, x_valid and x_bit are ignored except in the last busy cycle. No restart happens, the running product is unaffected, and busy and p_valid fall on schedule.
- R8: x_valid high in the last busy cycle starts the next operation at once. busy stays high and p_valid stays high across the boundary.
- R9: Operands at their extremes give exact results. All ones times all ones gives 2^(2N) - 2^(N+1) + 1, and a zero operand gives zero, so every saved carry drains by the 2N-th bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| y_load | input | 1 | Shift strobe for the Y holding register |
| y_bit | input | 1 | Serial Y data, least significant bit first |
| x_valid | input | 1 | X bit qualifier; while idle it starts an operation |
| x_bit | input | 1 | Serial X data, least significant bit first |
| busy | output | 1 | High during the 2N cycles of an operation |
| p_valid | output | 1 | p_bit carries a product bit |
| p_bit | output | 1 | Serial product, least significant bit first |

## Verification
A carry left behind in an adder stage, or a partial product aligned one stage off, corrupts the first product bit that passes through that stage. That error shows within the same 2N-bit frame, so any frame that does not match the reference product exposes it. A sequencer that counts one cycle too many or too few moves the fall of busy and p_valid. At the ports this shows as an early or late edge, and the next frame is misaligned. A working Y register overwritten by a mid-operation reload corrupts the upper product bits of the frame in flight. A restart accepted before the last busy cycle cuts the frame short.

// File: rtl/msm_pkg.sv
package msm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FEED  = 2'd1,
        PH_FLUSH = 2'd2
    } msm_phase_e;

    // one-bit full adder: returns {carry, sum}
    function automatic logic [1:0] fa_add(input logic a, input logic b, input logic c);
        fa_add = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
    endfunction

endpackage

// File: rtl/msm_sequencer.sv
module msm_sequencer
    import msm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x_valid,
    output logic start,
    output logic busy,
    output logic feed
);
    localparam int CW = $clog2(2 * N);
    localparam logic [CW-1:0] FEED_END = CW'(N - 1);
    localparam logic [CW-1:0] RUN_END  = CW'(2 * N - 1);

    typedef struct packed {
        msm_phase_e      phase;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t st_d, st_q;
    logic last;

    always_comb begin
        st_d  = st_q;
        busy  = (st_q.phase != PH_IDLE);
        feed  = (st_q.phase == PH_FEED);
        last  = (st_q.phase == PH_FLUSH) && (st_q.cnt == RUN_END);
        start = x_valid && (!busy || last);
        if (start) begin
            st_d.phase = PH_FEED;
            st_d.cnt   = '0;
        end else begin
            case (st_q.phase)
                PH_FEED: begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == FEED_END) st_d.phase = PH_FLUSH;
                end
                PH_FLUSH: begin
                    if (last) begin
                        st_d.phase = PH_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, cnt: '0};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/msm_y_store.sv
module msm_y_store #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         y_load,
    input  logic         y_bit,
    input  logic         capture,
    output logic [N-1:0] y_work
);
    typedef struct packed {
        logic [N-1:0] hold;
        logic [N-1:0] work;
    } ystore_t;

    ystore_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) st_d.work = st_q.hold;
        if (y_load) begin
            if (N > 1) st_d.hold = {y_bit, st_q.hold[N-1:1]};
            else       st_d.hold = y_bit;
        end
        y_work = st_q.work;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/msm_adder_row.sv
module msm_adder_row
    import msm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         a_bit,
    input  logic [N-1:0] y_vec,
    output logic         lsb
);
    typedef struct packed {
        logic [N-1:0] s;
        logic [N-1:0] c;
    } row_t;

    row_t st_d, st_q;
    logic [N-1:0] pp, sin, sn, cn;

    for (genvar j = 0; j < N; j++) begin : g_stage
        assign pp[j] = a_bit & y_vec[j];
        if (j == N - 1) begin : g_top
            assign sin[j] = 1'b0;
        end else begin : g_mid
            assign sin[j] = st_q.s[j+1];
        end
        assign {cn[j], sn[j]} = fa_add(pp[j], sin[j], st_q.c[j]);
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (step) begin
            st_d.s = sn;
            st_d.c = cn;
        end
        lsb = sn[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/msm_serial_mult.sv
module msm_serial_mult
    import msm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic y_load,
    input  logic y_bit,
    input  logic x_valid,
    input  logic x_bit,
    output logic busy,
    output logic p_valid,
    output logic p_bit
);
    typedef struct packed {
        logic x;
        logic pv;
        logic pb;
    } out_t;

    out_t         o_d, o_q;
    logic         start_w, busy_w, feed_w, lsb_w, a_w;
    logic [N-1:0] y_work_w;

    msm_sequencer #(.N(N)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_valid (x_valid),
        .start   (start_w),
        .busy    (busy_w),
        .feed    (feed_w)
    );

    msm_y_store #(.N(N)) u_ystore (
        .clk     (clk),
        .rst_n   (rst_n),
        .y_load  (y_load),
        .y_bit   (y_bit),
        .capture (start_w),
        .y_work  (y_work_w)
    );

    msm_adder_row #(.N(N)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_w),
        .step  (busy_w),
        .a_bit (a_w),
        .y_vec (y_work_w),
        .lsb   (lsb_w)
    );

    always_comb begin
        a_w    = feed_w & o_q.x;
        o_d.x  = x_valid & x_bit;
        o_d.pv = busy_w;
        o_d.pb = busy_w & lsb_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign busy    = busy_w;
    assign p_valid = o_q.pv;
    assign p_bit   = o_q.pb;

endmodule

// File: rtl/msm_serial_mult_chk.sv
module msm_serial_mult_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         p_valid,
    input logic         start,
    input logic [N-1:0] y_work
);
    localparam int LW = $clog2(2 * N) + 1;
    localparam logic [LW-1:0] LEN_END = LW'(2 * N - 1);

    logic [LW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     len_q <= '0;
        else if (start) len_q <= '0;
        else if (busy)  len_q <= len_q + 1'b1;
    end

    assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (len_q <= LEN_END));

    assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(len_q) == LEN_END));

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> p_valid);

    assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !p_valid);

    assert_yworking_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> $stable(y_work));

endmodule

bind msm_serial_mult msm_serial_mult_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_w),
    .p_valid (p_valid),
    .start   (start_w),
    .y_work  (y_work_w)
);

// File: tb/sim_msm_serial_mult.sv
module sim_msm_serial_mult;
    localparam int N  = 16;
    localparam int PW = 2 * N;

    logic clk = 1'b0, rst_n = 1'b0;
    logic y_load = 1'b0, y_bit = 1'b0, x_valid = 1'b0, x_bit = 1'b0;
    logic busy, p_valid, p_bit;

    int checks = 0, failures = 0, cyc = 0, got = 0;
    logic [N-1:0]  cur_y = '0;
    logic [PW-1:0] acc = '0, e = '0;
    logic [PW-1:0] exp_q[$];
    string         tag_q[$];
    string         t;

    msm_serial_mult #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .y_load(y_load), .y_bit(y_bit),
        .x_valid(x_valid), .x_bit(x_bit), .busy(busy), .p_valid(p_valid), .p_bit(p_bit)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [PW-1:0] r = '0;
        for (int i = 0; i < N; i++)
            if (a[i]) r = r + ({{N{1'b0}}, b} << i);
        return r;
    endfunction

    // output collector, samples on the falling edge
    always @(negedge clk) begin
        if (rst_n && p_valid) begin
            acc[got] = p_bit;
            got++;
            if (got == PW) begin
                got = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected product frame", acc, '0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(acc == e, t, acc, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // R2: strobes with idle gaps carrying junk on y_bit
    task automatic load_y(input logic [N-1:0] y, input bit gaps);
        for (int i = 0; i < N; i++) begin
            @(negedge clk); y_load = 1'b1; y_bit = y[i];
            if (gaps) begin
                @(negedge clk); y_load = 1'b0; y_bit = ~y[i];
            end
        end
        @(negedge clk); y_load = 1'b0;
        cur_y = y;
    endtask

    task automatic op(input logic [N-1:0] x, input logic [N-1:0] vmask, input logic [N-1:0] y_next,
                      input bit reload, input bit poke, input bit b2b, input string tag);
        logic [N-1:0] vm = vmask | {{(N-1){1'b0}}, 1'b1};
        exp_q.push_back(ref_mul(x & vm, cur_y));
        tag_q.push_back(tag);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            if (i == 1) begin
                check(busy == 1'b1, "R3 start accepted", PW'(busy), PW'(1));
                if (b2b) check(p_valid == 1'b1, "R8 valid continuous at boundary", PW'(p_valid), PW'(1));
            end
            x_valid = vm[i]; x_bit = x[i]; y_load = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            x_valid = poke & $urandom_range(0, 1);
            x_bit   = 1'(($urandom_range(0, 1)));
            y_load  = reload; y_bit = y_next[i];
        end
        if (reload) cur_y = y_next;
    endtask

    task automatic finish_idle(input bit poked);
        @(negedge clk); x_valid = 1'b0; y_load = 1'b0;
        check(busy == 1'b1, "R4 busy in last cycle", PW'(busy), PW'(1));
        @(negedge clk);
        check(busy == 1'b0, "R4 busy falls after 2N cycles", PW'(busy), PW'(0));
        check(p_valid == 1'b1, "R5 final bit valid", PW'(p_valid), PW'(1));
        @(negedge clk);
        check(p_valid == 1'b0, poked ? "R7 no restart from busy request" : "R5 valid falls", PW'(p_valid), PW'(0));
        repeat (2) @(negedge clk);
        check(busy == 1'b0, poked ? "R7 stays idle" : "R4 stays idle", PW'(busy), PW'(0));
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", PW'(busy), PW'(0));
        check(p_valid == 1'b0, "R1 p_valid in reset", PW'(p_valid), PW'(0));
        check(p_bit == 1'b0, "R1 p_bit in reset", PW'(p_bit), PW'(0));
        rst_n = 1'b1;

        load_y('1, 1'b0);
        op('1, '1, '0, 1'b0, 1'b0, 1'b0, "R9 all ones product");
        finish_idle(1'b0);

        load_y(16'hA5C3, 1'b1);
        op(16'h3C96, '1, 16'h0001, 1'b1, 1'b0, 1'b0, "R2 gapped Y load product");
        op(16'h0000, '1, 16'h8000, 1'b1, 1'b0, 1'b1, "R9 zero X product");
        op(16'hFFFF, '1, 16'hFFFF, 1'b1, 1'b1, 1'b1, "R6 reload in flight product");
        op(16'h8000, '1, 16'h1234, 1'b1, 1'b0, 1'b1, "R8 back to back product");
        op(16'hFFFF, 16'h0F0F, 16'h0000, 1'b1, 1'b1, 1'b1, "R3 gapped X valid product");
        op(16'hBEEF, '1, 16'h0000, 1'b0, 1'b1, 1'b1, "R9 zero Y product");
        finish_idle(1'b1);

        load_y(16'($urandom), 1'b0);
        for (int k = 0; k < 24; k++) begin
            logic [N-1:0] xr = 16'($urandom);
            logic [N-1:0] vr = ($urandom_range(0, 3) == 0) ? 16'($urandom) : '1;
            op(xr, vr, 16'($urandom), 1'b1, 1'($urandom_range(0, 1)), (k > 0), "R5 R6 random product");
        end
        finish_idle(1'b1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 all frames delivered", PW'(exp_q.size()), PW'(0));
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule